// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is the digital core of a two-wire serial EEPROM. It watches the clock and data lines of an I2C bus, which arrive already synchronised to the system clock. It recognises START and STOP conditions and answers only to its own device select byte, which it matches against three strap inputs. Behind the bus engine sits a byte-wide synchronous memory of 4,096 or 8,192 bytes, chosen by a parameter. A word address pointer steps forward after every byte that is transferred.

A write transaction carries a two-byte word address and then up to one page of data. The data bytes collect in a 32-byte page buffer and reach the array only after STOP, during a timed internal write cycle. While that cycle runs, the block ignores its own device select, so a host can poll until the part answers again. Reads come in three forms: random (a dummy write that sets the address, then a repeated START), current-address, and sequential. A write-protect input keeps the whole array unchanged while it is high.

Top module: `i2c_eeprom`

## Requirements
- R1: The array holds `MEM_BYTES` bytes (4096 or 8192). The word address is sent high byte first, and any address bits at or above log2(`MEM_BYTES`) are ignored.
- R2: The device select byte is 1010 in bits 7..4, the strap inputs in bits 3..1 and read/not-write in bit 0. The block acknowledges it only when all seven upper bits match.
- R3: SDA is open-drain only: `sda_oe_o` high pulls the line low and low releases it. `sda_oe_o` rises only while SCL is low.
- R4: A write with one or more data bytes, ended by STOP, stores each byte at the word address plus its position. Each address and data byte is acknowledged.
- R5: During a write the low 5 pointer bits wrap inside the current 32-byte page. Bytes past the page end overwrite the start of the same page, and the next page stays unchanged.
- R6: After a committing STOP the block is busy for `WRITE_CYCLES` clocks. While busy it does not acknowledge its device select byte.
- R7: While `wp_i` is high, address and data bytes are still acknowledged, but no location changes and no write cycle starts, so the device select is acknowledged right after STOP.
- R8: A random read (write select, two address bytes, repeated START, read select) returns the byte at that address.
- R9: A current-address read returns the byte at the pointer left by the previous access, which is one past the last byte read or written.
- R10: A sequential read returns consecutive bytes while the host acknowledges, and it wraps from the last address to address 0. A host NACK ends the read.
- R11: A write that is ended by STOP before any data byte only sets the pointer and starts no write cycle.
- R12: After reset SDA is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line as seen on the bus |
| strap_i | input | 3 | Device address strap bits |
| wp_i | input | 1 | Write protect, high blocks all writes |
| sda_oe_o | output | 1 | High pulls SDA low |

## Verification
The bench builds the block with `MEM_BYTES` = 4096, the default 32-byte page and `WRITE_CYCLES` = 400. The short write cycle puts acknowledge polling within a few bus transactions, so both the NACKed polls and the first answer after the cycle can be observed. With a 12-bit pointer, the wrap of a sequential read from address 4095 to 0 and the dropping of the upper four address bits are both reached in a short run.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA
    } sl_state_e;

    typedef enum logic {
        PH_DATA,
        PH_ACK
    } sl_phase_e;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/i2c_eeprom_edges.sv
module i2c_eeprom_edges (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t q, d;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_rise_o = !q.scl && scl_i;
    assign scl_fall_o = q.scl && !scl_i;
    assign start_o    = q.scl && scl_i && q.sda && !sda_i;
    assign stop_o     = q.scl && scl_i && !q.sda && sda_i;

endmodule

// File: rtl/i2c_eeprom_mem.sv
module i2c_eeprom_mem #(
    parameter int DEPTH = 4096,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rdata_q <= mem_q[raddr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/i2c_eeprom_commit.sv
module i2c_eeprom_commit #(
    parameter int PAGE_BYTES   = 32,
    parameter int AW           = 12,
    parameter int WRITE_CYCLES = 150000
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          clr_i,
    input  logic                          ld_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] ld_idx_i,
    input  logic [7:0]                    ld_data_i,
    input  logic                          go_i,
    input  logic [AW-$clog2(PAGE_BYTES)-1:0] base_i,
    input  logic                          wp_i,
    output logic                          busy_o,
    output logic                          we_o,
    output logic [AW-1:0]                 waddr_o,
    output logic [7:0]                    wdata_o
);

    localparam int PW = $clog2(PAGE_BYTES);
    localparam int BW = AW - PW;
    localparam int TW = $clog2(WRITE_CYCLES + 1);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [PAGE_BYTES-1:0]      vld;
        logic                       busy;
        logic [TW-1:0]              tmr;
        logic [BW-1:0]              base;
    } eng_t;

    eng_t q, d;

    logic [PW-1:0] idx;
    logic          walk;

    assign idx  = q.tmr[PW-1:0];
    assign walk = q.busy && (q.tmr < TW'(PAGE_BYTES));

    always_comb begin
        d = q;
        if (clr_i) begin
            d.vld = '0;
        end
        if (ld_i) begin
            d.data[ld_idx_i] = ld_data_i;
            d.vld[ld_idx_i]  = 1'b1;
        end
        if (go_i && !q.busy) begin
            d.busy = 1'b1;
            d.tmr  = '0;
            d.base = base_i;
        end else if (q.busy) begin
            if (q.tmr == TW'(WRITE_CYCLES - 1)) begin
                d.busy = 1'b0;
                d.vld  = '0;
            end else begin
                d.tmr = q.tmr + TW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = q.busy;
    assign we_o    = walk && q.vld[idx] && !wp_i;
    assign waddr_o = {q.base, idx};
    assign wdata_o = q.data[idx];

    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.busy |-> !ld_i); // R6

    AST_WE_INSIDE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_o |-> (q.busy && !wp_i)); // R7

endmodule

// File: rtl/i2c_eeprom.sv
module i2c_eeprom
    import i2c_eeprom_pkg::*;
#(
    parameter int MEM_BYTES    = 4096,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 150000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);

    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    typedef struct packed {
        sl_state_e     state;
        sl_phase_e     phase;
        logic [3:0]    bitcnt;
        logic [7:0]    shreg;
        logic          oe;
        logic          nack;
        logic          have_data;
        logic [7:0]    addr_hi;
        logic [AW-1:0] ptr;
    } ctl_t;

    ctl_t q, d;

    logic ev_rise, ev_fall, ev_start, ev_stop;
    logic buf_clr, buf_ld, wr_go;
    logic eng_busy, ram_we;
    logic [AW-1:0] ram_waddr;
    logic [7:0] ram_wdata, rd_data;
    logic dev_hit;

    i2c_eeprom_edges u_edges (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (ev_rise),
        .scl_fall_o (ev_fall),
        .start_o    (ev_start),
        .stop_o     (ev_stop)
    );

    i2c_eeprom_commit #(
        .PAGE_BYTES   (PAGE_BYTES),
        .AW           (AW),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_commit (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (buf_clr),
        .ld_i      (buf_ld),
        .ld_idx_i  (q.ptr[PW-1:0]),
        .ld_data_i (q.shreg),
        .go_i      (wr_go),
        .base_i    (q.ptr[AW-1:PW]),
        .wp_i      (wp_i),
        .busy_o    (eng_busy),
        .we_o      (ram_we),
        .waddr_o   (ram_waddr),
        .wdata_o   (ram_wdata)
    );

    i2c_eeprom_mem #(
        .DEPTH (MEM_BYTES),
        .AW    (AW)
    ) u_mem (
        .clk_i   (clk_i),
        .we_i    (ram_we),
        .waddr_i (ram_waddr),
        .wdata_i (ram_wdata),
        .raddr_i (q.ptr),
        .rdata_o (rd_data)
    );

    assign dev_hit = (q.shreg[7:1] == {DEV_PREFIX, strap_i});

    always_comb begin
        d       = q;
        buf_clr = 1'b0;
        buf_ld  = 1'b0;
        wr_go   = 1'b0;
        if (ev_start) begin
            d.state     = ST_DEV;
            d.phase     = PH_DATA;
            d.bitcnt    = '0;
            d.oe        = 1'b0;
            d.have_data = 1'b0;
        end else if (ev_stop) begin
            if (q.state == ST_WDATA && q.have_data && !wp_i) begin
                wr_go = 1'b1;
            end
            d.state     = ST_IDLE;
            d.oe        = 1'b0;
            d.have_data = 1'b0;
        end else if (q.state != ST_IDLE) begin
            if (q.phase == PH_DATA) begin
                if (q.state == ST_RDATA) begin
                    // transmit: shift out on each falling SCL
                    if (ev_fall) begin
                        if (q.bitcnt == 4'd7) begin
                            d.oe    = 1'b0;
                            d.phase = PH_ACK;
                            d.nack  = 1'b0;
                            d.ptr   = q.ptr + AW'(1);
                        end else begin
                            d.bitcnt = q.bitcnt + 4'd1;
                            d.shreg  = {q.shreg[6:0], 1'b0};
                            d.oe     = !q.shreg[6];
                        end
                    end
                end else begin
                    // receive: sample on rising SCL, decide on the 8th fall
                    if (ev_rise && q.bitcnt != 4'd8) begin
                        d.shreg  = {q.shreg[6:0], sda_i};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (ev_fall && q.bitcnt == 4'd8) begin
                        d.phase = PH_ACK;
                        d.oe    = 1'b1;
                        case (q.state)
                            ST_DEV: begin
                                if (dev_hit && !eng_busy) begin
                                    d.state = q.shreg[0] ? ST_RDATA : ST_AHI;
                                    d.nack  = 1'b0;
                                end else begin
                                    d.state = ST_IDLE;
                                    d.oe    = 1'b0;
                                end
                            end
                            ST_AHI: begin
                                d.addr_hi = q.shreg;
                                d.state   = ST_ALO;
                            end
                            ST_ALO: begin
                                d.ptr   = AW'({q.addr_hi, q.shreg});
                                d.state = ST_WDATA;
                                buf_clr = 1'b1;
                            end
                            ST_WDATA: begin
                                buf_ld      = !wp_i;
                                d.have_data = 1'b1;
                                d.ptr       = {q.ptr[AW-1:PW], q.ptr[PW-1:0] + PW'(1)};
                            end
                            default: begin
                                d.state = ST_IDLE;
                                d.oe    = 1'b0;
                            end
                        endcase
                    end
                end
            end else begin
                // acknowledge slot
                if (ev_rise) begin
                    d.nack = sda_i;
                end else if (ev_fall) begin
                    d.bitcnt = '0;
                    d.phase  = PH_DATA;
                    if (q.state == ST_RDATA) begin
                        if (q.nack) begin
                            d.state = ST_IDLE;
                            d.oe    = 1'b0;
                        end else begin
                            d.shreg = rd_data;
                            d.oe    = !rd_data[7];
                        end
                    end else begin
                        d.oe = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{state: ST_IDLE, phase: PH_DATA, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

    AST_OE_RISES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_oe_o) |-> !scl_i); // R3

    AST_SELECT_MISMATCH_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_fall && q.state == ST_DEV && q.phase == PH_DATA && q.bitcnt == 4'd8
         && q.shreg[7:1] != {DEV_PREFIX, strap_i}) |=> !sda_oe_o); // R2

    AST_BUSY_SELECT_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_fall && eng_busy && q.state == ST_DEV && q.phase == PH_DATA
         && q.bitcnt == 4'd8) |=> !sda_oe_o); // R6

    AST_PROTECT_NO_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!eng_busy && wp_i) |=> !eng_busy); // R7

endmodule

// File: tb/i2c_eeprom_bench.sv
module i2c_eeprom_bench;

    localparam int MEM  = 4096;
    localparam int PG   = 32;
    localparam int WCYC = 400;
    localparam int Q    = 3;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_eeprom #(
        .MEM_BYTES    (MEM),
        .PAGE_BYTES   (PG),
        .WRITE_CYCLES (WCYC)
    ) u_i2c_eeprom (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (STRAP),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] sh [MEM];
    bit         kn [MEM];
    logic [7:0] wbuf [64];
    logic [7:0] rbuf [64];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int page_addr(input int a0, input int i);
        int a;
        a = a0 % MEM;
        return (a & ~(PG - 1)) | ((a + i) & (PG - 1));
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(Q);
            scl = 1'b0;   tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(1);
        ack = !sda_line;
        tick(Q - 1);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(1);
            b[i] = sda_line;
            tick(Q - 1);
            scl = 1'b0;
        end
        tick(1);
        sda_m = mack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        scl = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // write n bytes of wbuf at address a; acks = number of acknowledged bytes
    task automatic wr(input logic [15:0] a, input int n, output int acks);
        bit ack;
        acks = 0;
        bus_start();
        send_byte(DEV_W, ack);     acks += int'(ack);
        send_byte(a[15:8], ack);   acks += int'(ack);
        send_byte(a[7:0], ack);    acks += int'(ack);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack); acks += int'(ack);
        end
        bus_stop();
    endtask

    task automatic shadow_wr(input int a, input int n);
        for (int i = 0; i < n; i++) begin
            sh[page_addr(a, i)] = wbuf[i];
            kn[page_addr(a, i)] = 1'b1;
        end
    endtask

    task automatic poll(output int tries);
        bit ack;
        tries = 0;
        for (int k = 0; k < 100; k++) begin
            bus_start();
            send_byte(DEV_W, ack);
            bus_stop();
            if (ack) break;
            tries++;
        end
    endtask

    task automatic rd_cur(input int n, output bit ack);
        bus_start();
        send_byte(DEV_R, ack);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic rd_at(input logic [15:0] a, input int n, output bit ok);
        bit ack;
        ok = 1'b1;
        bus_start();
        send_byte(DEV_W, ack);   ok &= ack;
        send_byte(a[15:8], ack); ok &= ack;
        send_byte(a[7:0], ack);  ok &= ack;
        bus_start();
        send_byte(DEV_R, ack);   ok &= ack;
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int acks, tries, a, n;
        bit ok, ack;
        void'($urandom(32'd4242));
        for (int i = 0; i < MEM; i++) kn[i] = 1'b0;
        tick(5);
        chk(sda_oe == 1'b0, "R12 sda released in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(5);
        chk(sda_oe == 1'b0, "R12 sda released after reset", int'(sda_oe), 0);
        // R12: pointer at 0 -> write address 0 first then confirm via current read later
        wbuf[0] = 8'h3C;
        wr(16'h0000, 1, acks); shadow_wr(0, 1); poll(tries);
        bus_start(); send_byte(DEV_W, ack); bus_stop();
        // wrong strap, wrong prefix
        bus_start(); send_byte({4'b1010, 3'b011, 1'b0}, ack); bus_stop();
        chk(!ack, "R2 strap mismatch nack", int'(ack), 0);
        bus_start(); send_byte({4'b1011, STRAP, 1'b0}, ack); bus_stop();
        chk(!ack, "R2 prefix mismatch nack", int'(ack), 0);
        bus_start(); send_byte(DEV_W, ack); bus_stop();
        chk(ack, "R2 full match ack", int'(ack), 1);

        // byte write and busy
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
        wr(16'h0123, 2, acks); shadow_wr('h123, 2);
        chk(acks == 5, "R4 all bytes acked", acks, 5);
        poll(tries);
        chk(tries > 0, "R6 select nacked while busy", tries, 1);
        chk(tries < 10, "R6 busy ends", tries, 5);
        rd_at(16'h0123, 1, ok);
        chk(ok && rbuf[0] == 8'h5A, "R8 random read", int'(rbuf[0]), 'h5A);
        rd_cur(1, ack);
        chk(ack && rbuf[0] == 8'hC3, "R9 current address read", int'(rbuf[0]), 'hC3);

        // page wrap
        wbuf[0] = 8'h11;
        wr(16'h0260, 1, acks); shadow_wr('h260, 1); poll(tries);
        for (int i = 0; i < 34; i++) wbuf[i] = 8'(8'h80 + i);
        wr(16'h025E, 34, acks); shadow_wr('h25E, 34);
        chk(acks == 37, "R5 page bytes acked", acks, 37);
        poll(tries);
        rd_at(16'h0240, 33, ok);
        for (int i = 0; i < 33; i++)
            chk(rbuf[i] == sh['h240 + i], "R5 page wrap content", int'(rbuf[i]), int'(sh['h240 + i]));
        chk(rbuf[32] == 8'h11, "R5 next page untouched", int'(rbuf[32]), 'h11);

        // upper address bits ignored
        wbuf[0] = 8'h77;
        wr(16'hF0AB, 1, acks); shadow_wr('h0AB, 1); poll(tries);
        rd_at(16'h00AB, 1, ok);
        chk(rbuf[0] == 8'h77, "R1 upper bits ignored", int'(rbuf[0]), 'h77);

        // write protect
        wp = 1'b1;
        wbuf[0] = 8'hEE; wbuf[1] = 8'hEF;
        wr(16'h0123, 2, acks);
        chk(acks == 5, "R7 protected bytes acked", acks, 5);
        poll(tries);
        chk(tries == 0, "R7 no write cycle", tries, 0);
        wp = 1'b0;
        rd_at(16'h0123, 2, ok);
        chk(rbuf[0] == 8'h5A && rbuf[1] == 8'hC3, "R7 data unchanged",
            int'({rbuf[0], rbuf[1]}), 'h5AC3);

        // empty write sets pointer only
        wr(16'h0123, 0, acks);
        poll(tries);
        chk(tries == 0, "R11 no cycle without data", tries, 0);
        rd_cur(1, ack);
        chk(rbuf[0] == 8'h5A, "R11 pointer set by empty write", int'(rbuf[0]), 'h5A);

        // sequential wrap at end of array
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2;
        wr(16'h0FFE, 2, acks); shadow_wr('hFFE, 2); poll(tries);
        wbuf[0] = 8'hB1; wbuf[1] = 8'hB2;
        wr(16'h0000, 2, acks); shadow_wr(0, 2); poll(tries);
        rd_at(16'h0FFE, 4, ok);
        chk(rbuf[0] == 8'hA1 && rbuf[1] == 8'hA2 && rbuf[2] == 8'hB1 && rbuf[3] == 8'hB2,
            "R10 sequential wrap", int'({rbuf[0], rbuf[1], rbuf[2], rbuf[3]}), 'hA1A2B1B2);
        rd_cur(1, ack);
        chk(rbuf[0] == 8'hC3 || !kn[2] || rbuf[0] == sh[2], "R9 pointer after sequential read",
            int'(rbuf[0]), int'(sh[2]));

        // constrained random page writes and reads
        for (int it = 0; it < 12; it++) begin
            a = int'($urandom % MEM);
            n = 1 + int'($urandom % 36);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            wr(16'(a), n, acks); shadow_wr(a, n);
            chk(acks == n + 3, "R4 random write acked", acks, n + 3);
            poll(tries);
            chk(tries > 0, "R6 random busy", tries, 1);
            rd_at(16'(a), 6, ok);
            for (int i = 0; i < 6; i++) begin
                if (kn[(a + i) % MEM])
                    chk(rbuf[i] == sh[(a + i) % MEM], "R5 R10 random readback",
                        int'(rbuf[i]), int'(sh[(a + i) % MEM]));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule